// File: doc/BRIEF.md
# Preemptive DMA Channel Arbiter

This block decides which of several DMA channels may use a single shared data transfer engine. Each channel has its own trigger line. A trigger on an enabled channel sets a pending flag for that channel, and the flag stays set until the channel's descriptor finishes. Each channel also has a 2-bit priority and a flag that says whether it may be preempted.

When the engine is idle, the arbiter picks the best pending channel. It presents that channel's index together with a one-cycle start strobe. The engine reports two events: the end of each single transfer, and the end of the whole descriptor. A running channel that may be preempted gives up the engine at a single-transfer boundary if a strictly better pending channel exists. It keeps its pending flag, so it is granted again later and the engine can resume its saved position. A channel that may not be preempted keeps the engine until its descriptor completes.

Top module: `dma_share_arbiter`

## Requirements
- R1: A one-cycle trigger on an enabled channel sets that channel's pending flag. The channel is then granted later without any further trigger, independently of the other channels.
- R2: At most one channel holds the engine. After reset `grant_valid` and `start` are 0. `grant_valid` falls in the cycle after `desc_done` is seen, and stays 0 while nothing is pending.
- R3: Priority is a 2-bit field per channel, `chan_prio[2*i+1:2*i]`, giving four levels. The value 0 is the most urgent and 3 the least.
- R4: A preemptable active channel is replaced only on a cycle where `xfer_done` is 1 (and `desc_done` is 0), and only by a pending channel with a strictly more urgent priority. On equal priority there is no switch.
- R5: A channel whose `preempt_ok` bit is 0 keeps the grant through any number of `xfer_done` pulses, until `desc_done`.
- R6: Among equally urgent pending channels, the lowest index is granted first.
- R7: A preempted channel stays pending and is granted again after the preempting descriptor completes.
- R8: A trigger on a channel that is already pending or active adds no extra grant; one `desc_done` clears it.
- R9: A channel with `chan_en` low ignores triggers. Dropping `chan_en` clears its pending flag. If that channel is active, it also ends its grant in the next cycle.
- R10: When idle with a channel pending, the grant appears on the next clock edge. `start` is high for exactly that one cycle, `grant_idx` holds the channel, and `start` is never high without `grant_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | NCH | Per-channel trigger pulses |
| chan_en | input | NCH | Per-channel enable |
| chan_prio | input | 2*NCH | Per-channel priority, 0 most urgent |
| preempt_ok | input | NCH | Per-channel: may be preempted at transfer boundaries |
| xfer_done | input | 1 | Engine finished one single transfer |
| desc_done | input | 1 | Engine finished the active descriptor |
| grant_valid | output | 1 | A channel holds the engine |
| grant_idx | output | $clog2(NCH) | Index of the granting channel |
| start | output | 1 | One-cycle strobe on every new grant |

## Verification
The bench targets preemption timing. A design that switched channels as soon as a better request appeared, rather than waiting for a transfer boundary, would issue a start while `xfer_done` is low. A design that compared priorities with less-than-or-equal would swap between equal channels. It also checks that a non-preemptable channel holds on through several boundaries, and that a preempted channel returns afterwards; a design that cleared the pending flag on preemption would lose that channel's remaining work. Duplicate triggers and mid-pending disables are exercised, which would expose a counter in place of a flag, or a pending bit that survives its enable being cleared.

// File: rtl/dma_share_arbiter.sv
module dma_share_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   trig,
  input  logic [NCH-1:0]   chan_en,
  input  logic [2*NCH-1:0] chan_prio,
  input  logic [NCH-1:0]   preempt_ok,
  input  logic             xfer_done,
  input  logic             desc_done,
  output logic             grant_valid,
  output logic [IW-1:0]    grant_idx,
  output logic             start
);

  logic [NCH-1:0] pend, live;
  logic           busy, strobe, found;
  logic [IW-1:0]  cur, best_idx;
  logic [1:0]     best_pr, cur_pr;

  assign live   = pend & chan_en;
  assign cur_pr = chan_prio[2*int'(cur) +: 2];

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_pr  = 2'd3;
    for (int i = 0; i < NCH; i++)
      if (live[i] && (!found || chan_prio[2*i +: 2] < best_pr)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_pr  = chan_prio[2*i +: 2];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        pend[i] <= chan_en[i] &
                   (trig[i] | (pend[i] & ~(busy && desc_done && cur == IW'(i))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (busy) begin
        if (desc_done || !chan_en[cur]) begin
          busy <= 1'b0;
        end else if (xfer_done && preempt_ok[cur] && found && best_pr < cur_pr) begin
          cur    <= best_idx;
          strobe <= 1'b1;
        end
      end else if (found) begin
        busy   <= 1'b1;
        cur    <= best_idx;
        strobe <= 1'b1;
      end
    end
  end

  assign grant_valid = busy;
  assign grant_idx   = cur;
  assign start       = strobe;

endmodule

// File: rtl/dma_share_arbiter_chk.sv
module dma_share_arbiter_chk #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] preempt_ok,
  input logic           xfer_done,
  input logic           grant_valid,
  input logic [IW-1:0]  grant_idx,
  input logic           start,
  input logic [NCH-1:0] pend
);

  a_r10_start_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> grant_valid);

  a_r2_active_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> pend[grant_idx]);

  a_r4_switch_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !xfer_done) |=> !start);

  a_r5_locked_keeps_engine: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !preempt_ok[grant_idx]) |=> !start);

  a_r9_disable_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en != '1) |=> ((pend & ~$past(chan_en)) == '0));

  a_r10_single_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start || $past(xfer_done));

endmodule

bind dma_share_arbiter dma_share_arbiter_chk #(.NCH(NCH)) chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .preempt_ok(preempt_ok),
  .xfer_done(xfer_done), .grant_valid(grant_valid), .grant_idx(grant_idx),
  .start(start), .pend(pend)
);

// File: tb/dma_share_arbiter_test.sv
`timescale 1ns/1ps
module dma_share_arbiter_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [NCH-1:0] trig = '0, chan_en = '1, preempt_ok = '0;
  logic [2*NCH-1:0] chan_prio = '0;
  logic           xfer_done = 1'b0, desc_done = 1'b0;
  logic           grant_valid, start;
  logic [1:0]     grant_idx;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  bit ended = 1'b0;

  dma_share_arbiter #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .chan_en(chan_en),
    .chan_prio(chan_prio), .preempt_ok(preempt_ok), .xfer_done(xfer_done),
    .desc_done(desc_done), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .start(start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(input logic [NCH-1:0] m);
    trig = m;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic beat();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic finish_desc();
    desc_done = 1'b1;
    @(negedge clk);
    desc_done = 1'b0;
  endtask

  task automatic set_prio(input int ch, input logic [1:0] p);
    chan_prio[2*ch +: 2] = p;
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: every start must match the next expected grant
  always @(negedge clk) begin
    if (rst_n && start) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected start", grant_idx, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(grant_idx == e && grant_valid, "R1 grant order", grant_idx, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(!grant_valid && !start, "R2 reset idle", grant_valid, 0);

    // R1/R10: single trigger, grant timing and one-cycle strobe
    set_prio(2, 2'd1);
    exp_q.push_back(2);
    pulse_trig(4'b0100);
    check(start == 1'b0, "R10 no start before pending is seen", start, 0);
    @(negedge clk);
    check(start == 1'b1, "R10 start on next edge", start, 1);
    @(negedge clk);
    check(!start && grant_valid, "R10 start lasts one cycle", start, 0);
    beat(); beat();
    check(grant_valid && grant_idx == 2, "R1 grant held across transfers", grant_idx, 2);
    finish_desc();
    check(!grant_valid, "R2 idle after descriptor", grant_valid, 0);
    wait_n(2);
    check(!grant_valid, "R2 stays idle with nothing pending", grant_valid, 0);

    // R6: equal priority tie goes to lowest index
    set_prio(1, 2'd2); set_prio(3, 2'd2);
    exp_q.push_back(1); exp_q.push_back(3);
    pulse_trig(4'b1010);
    wait_n(3); finish_desc();
    wait_n(3);
    check(grant_idx == 3, "R6 second tied channel served", grant_idx, 3);
    finish_desc(); wait_n(2);

    // R3: value 0 beats value 3
    set_prio(0, 2'd3); set_prio(2, 2'd0);
    exp_q.push_back(2); exp_q.push_back(0);
    pulse_trig(4'b0101);
    wait_n(3); finish_desc();
    wait_n(3); finish_desc(); wait_n(2);

    // R4/R7: preemption at boundary, preempted channel returns
    preempt_ok = 4'b1000;
    set_prio(3, 2'd2); set_prio(0, 2'd0);
    exp_q.push_back(3);
    pulse_trig(4'b1000);
    wait_n(3);
    exp_q.push_back(0);
    pulse_trig(4'b0001);
    wait_n(3);
    check(grant_idx == 3, "R4 no switch without boundary", grant_idx, 3);
    beat();
    check(grant_idx == 0 && start, "R4 switch at boundary", grant_idx, 0);
    exp_q.push_back(3);
    wait_n(1); finish_desc();
    wait_n(3);
    check(grant_valid && grant_idx == 3, "R7 preempted channel regranted", grant_idx, 3);
    finish_desc(); wait_n(2);

    // R5: non-preemptable channel holds through boundaries
    preempt_ok = 4'b0000;
    exp_q.push_back(3);
    pulse_trig(4'b1000);
    wait_n(3);
    pulse_trig(4'b0001);
    wait_n(2); beat(); beat();
    check(grant_idx == 3 && grant_valid, "R5 locked channel keeps engine", grant_idx, 3);
    exp_q.push_back(0);
    finish_desc(); wait_n(3);
    check(grant_idx == 0, "R5 waiting channel served after descriptor", grant_idx, 0);
    finish_desc(); wait_n(2);

    // R4: equal priority does not preempt
    preempt_ok = '1;
    set_prio(1, 2'd1); set_prio(2, 2'd1);
    exp_q.push_back(2);
    pulse_trig(4'b0100);
    wait_n(3);
    pulse_trig(4'b0010);
    wait_n(2); beat();
    check(grant_idx == 2, "R4 equal priority no preempt", grant_idx, 2);
    exp_q.push_back(1);
    finish_desc(); wait_n(3); finish_desc(); wait_n(2);

    // R8: repeated triggers collapse into one
    exp_q.push_back(1);
    pulse_trig(4'b0010);
    pulse_trig(4'b0010);
    wait_n(2);
    pulse_trig(4'b0010);
    wait_n(1);
    finish_desc(); wait_n(4);
    check(!grant_valid, "R8 duplicate triggers not counted twice", grant_valid, 0);

    // R9: disabled channel ignores triggers and loses pending state
    chan_en[2] = 1'b0;
    pulse_trig(4'b0100);
    wait_n(4);
    check(!grant_valid, "R9 disabled channel ignores trigger", grant_valid, 0);
    chan_en[2] = 1'b1;
    preempt_ok = '0;
    exp_q.push_back(1);
    pulse_trig(4'b0010);
    wait_n(3);
    pulse_trig(4'b0100);
    wait_n(1);
    chan_en[2] = 1'b0;
    wait_n(1);
    chan_en[2] = 1'b1;
    wait_n(1);
    finish_desc(); wait_n(4);
    check(!grant_valid, "R9 disable clears pending flag", grant_valid, 0);
    exp_q.push_back(3);
    pulse_trig(4'b1000);
    wait_n(3);
    chan_en[3] = 1'b0;
    wait_n(1);
    check(!grant_valid, "R9 disabling active channel ends grant", grant_valid, 0);
    chan_en[3] = 1'b1;
    wait_n(3);
    check(!grant_valid, "R9 no regrant after disable", grant_valid, 0);

    check(exp_q.size() == 0, "R1 all expected grants issued", exp_q.size(), 0);
    wrap_up();
  end
endmodule